// File: doc/BRIEF.md
# Flag-Setting 32-bit ALU

This block is the arithmetic and logic stage of a load-store processor datapath. It is purely combinational. Each cycle it takes two 32-bit operands and a 4-bit operation code, and it returns a 32-bit result together with the next value of the four condition flags: negative, zero, carry and overflow.

The second operand normally arrives from a barrel shifter placed in front of this block. The carry that shifter produced comes in on its own pin, and the logical operations use it as their carry flag. The current flags come in as a 4-bit vector, and the block returns the updated vector. The flags change only when the set-flags input is high, or when the operation is one of the four probe operations. The probe operations compute a value purely to set the flags. For those four, the result-valid output is low and the result bus reads zero, so the register file writes nothing back.

Operand sizes are fixed at 32 bits by default, but the datapath width is a parameter. The operation code is a plain 4-bit field, decoded as listed in R1.

Top module: `flag_alu`

## Requirements
- R1: The opcode is decoded as follows: 0 AND, 1 XOR, 2 SUB, 3 RSUB, 4 ADD, 5 ADDC, 6 SUBC, 7 RSUBC, 8 TSTAND, 9 TSTXOR, 10 CMPSUB, 11 CMPADD, 12 OR, 13 PASS, 14 CLEAR, 15 PASSN. ADD returns a+b and SUB returns a-b, both modulo 2^32. ADDC returns a+b+C, where C is flags_in bit 1.
- R2: The reverse forms swap the operands. RSUB returns b-a. RSUBC returns b-a-(1-C).
- R3: SUBC returns a-b-(1-C); the carry flag acts as "no borrow".
- R4: AND, XOR and OR combine the operands bit by bit. CLEAR returns a AND NOT b.
- R5: PASS returns op_b and PASSN returns NOT op_b. Neither depends on op_a.
- R6: TSTAND, TSTXOR, CMPSUB and CMPADD drive result_valid low and result to zero. They update the flags whatever set_flags is, using AND, XOR, subtract and add respectively.
- R7: The flag vector flags_in/flags_out is laid out as bit 3 N, bit 2 Z, bit 1 C, bit 0 V. When the flags update, N equals bit 31 of the computed value, and Z is 1 exactly when all 32 bits of that value are zero.
- R8: For the twelve non-probe operations, flags_out equals flags_in whenever set_flags is 0.
- R9: For the arithmetic operations, an update sets C to the adder's carry out and V to signed overflow. For subtracting forms, C is 1 when no borrow occurred.
- R10: For the logical and pass operations, an update sets C to shift_carry and leaves V equal to flags_in bit 0.
- R11: result_valid is 1 for every non-probe operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, output of the shifter stage |
| opcode | input | 4 | Operation select, encoded as in R1 |
| set_flags | input | 1 | Request a flag update for non-probe operations |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| shift_carry | input | 1 | Carry produced by the shifter |
| result | output | 32 | Computed result, zero for probe operations |
| result_valid | output | 1 | High when the result is to be written back |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
The assertions assume that the inputs settle within a cycle and are never X or Z. They also assume that the opcode is always one of the sixteen codes, so every input value is meaningful. The bench changes the inputs only at one clock edge and compares the outputs at the opposite edge, so it never sees a partially updated combination. Directed cases cover the carry, borrow, overflow and zero boundaries. A seeded pseudo-random sweep then covers every opcode, with set_flags, the incoming flags and the shifter carry all varied.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_AND    = 4'd0,
    OP_XOR    = 4'd1,
    OP_SUB    = 4'd2,
    OP_RSUB   = 4'd3,
    OP_ADD    = 4'd4,
    OP_ADDC   = 4'd5,
    OP_SUBC   = 4'd6,
    OP_RSUBC  = 4'd7,
    OP_TSTAND = 4'd8,
    OP_TSTXOR = 4'd9,
    OP_CMPSUB = 4'd10,
    OP_CMPADD = 4'd11,
    OP_OR     = 4'd12,
    OP_PASS   = 4'd13,
    OP_CLEAR  = 4'd14,
    OP_PASSN  = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // Operations that go through the adder
  function automatic logic uses_adder(alu_op_e op);
    case (op)
      OP_SUB, OP_RSUB, OP_ADD, OP_ADDC, OP_SUBC, OP_RSUBC,
      OP_CMPSUB, OP_CMPADD: uses_adder = 1'b1;
      default:              uses_adder = 1'b0;
    endcase
  endfunction

  // Operations that only probe the flags and write no result
  function automatic logic is_probe(alu_op_e op);
    case (op)
      OP_TSTAND, OP_TSTXOR, OP_CMPSUB, OP_CMPADD: is_probe = 1'b1;
      default:                                    is_probe = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  input  logic         carry_flag,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  logic         swap;
  logic         invert;
  logic         cin;
  logic [W-1:0] x;
  logic [W-1:0] y;
  logic [W:0]   wide;

  always_comb begin
    swap   = (op == OP_RSUB) || (op == OP_RSUBC);
    invert = 1'b0;
    cin    = 1'b0;
    case (op)
      OP_SUB, OP_RSUB, OP_CMPSUB: begin invert = 1'b1; cin = 1'b1;       end
      OP_SUBC, OP_RSUBC:          begin invert = 1'b1; cin = carry_flag; end
      OP_ADDC:                    begin cin = carry_flag;                end
      default:                    begin                                  end
    endcase
  end

  assign x    = swap ? b : a;
  assign y    = invert ? ~(swap ? a : b) : (swap ? a : b);
  assign wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign sum  = wide[W-1:0];
  assign cout = wide[W];
  assign ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);

  // Carry-in of the plain forms never depends on the flag
  always_comb begin
    if (op == OP_ADD) begin
      p_add_plain_r1: assert (sum == a + b)
        else $error("p_add_plain_r1");
    end
    if (op == OP_RSUB) begin
      p_rsub_swap_r2: assert (sum == b - a)
        else $error("p_rsub_swap_r2");
    end
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] res
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      case (op)
        OP_AND, OP_TSTAND: res[i] = a[i] & b[i];
        OP_XOR, OP_TSTXOR: res[i] = a[i] ^ b[i];
        OP_OR:             res[i] = a[i] | b[i];
        OP_CLEAR:          res[i] = a[i] & ~b[i];
        OP_PASS:           res[i] = b[i];
        OP_PASSN:          res[i] = ~b[i];
        default:           res[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] value,
  input  alu_op_e      op,
  input  logic         set_flags,
  input  flags_t       cur,
  input  logic         add_cout,
  input  logic         add_ovf,
  input  logic         shift_carry,
  output flags_t       nxt
);

  logic update;

  assign update = set_flags || is_probe(op);

  always_comb begin
    nxt = cur;
    if (update) begin
      nxt.n = value[W-1];
      nxt.z = ~|value;
      if (uses_adder(op)) begin
        nxt.c = add_cout;
        nxt.v = add_ovf;
      end else begin
        nxt.c = shift_carry;
      end
    end
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_pkg::*;
#(
  parameter int W      = 32,
  parameter int OPW    = 4,
  parameter int FLAGSW = 4
) (
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  input  logic [OPW-1:0]    opcode,
  input  logic              set_flags,
  input  logic [FLAGSW-1:0] flags_in,
  input  logic              shift_carry,
  output logic [W-1:0]      result,
  output logic              result_valid,
  output logic [FLAGSW-1:0] flags_out
);

  localparam int CBIT = 1;

  alu_op_e      op;
  flags_t       cur;
  flags_t       nxt;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic         add_ovf;
  logic [W-1:0] log_res;
  logic [W-1:0] value;
  logic         probe;

  assign op    = alu_op_e'(opcode);
  assign cur   = flags_t'(flags_in);
  assign probe = is_probe(op);

  alu_addsub #(.W(W)) u_addsub (
    .a          (op_a),
    .b          (op_b),
    .op         (op),
    .carry_flag (flags_in[CBIT]),
    .sum        (add_sum),
    .cout       (add_cout),
    .ovf        (add_ovf)
  );

  alu_logic #(.W(W)) u_logic (
    .a   (op_a),
    .b   (op_b),
    .op  (op),
    .res (log_res)
  );

  assign value = uses_adder(op) ? add_sum : log_res;

  alu_flags #(.W(W)) u_flags (
    .value       (value),
    .op          (op),
    .set_flags   (set_flags),
    .cur         (cur),
    .add_cout    (add_cout),
    .add_ovf     (add_ovf),
    .shift_carry (shift_carry),
    .nxt         (nxt)
  );

  assign result       = probe ? '0 : value;
  assign result_valid = ~probe;
  assign flags_out    = nxt;

  always_comb begin
    if (opcode >= 4'd8 && opcode <= 4'd11) begin
      p_probe_silent_r6: assert (!result_valid && result == '0)
        else $error("p_probe_silent_r6");
    end else begin
      p_valid_r11: assert (result_valid)
        else $error("p_valid_r11");
    end
    if (!set_flags && !(opcode >= 4'd8 && opcode <= 4'd11)) begin
      p_hold_flags_r8: assert (flags_out == flags_in)
        else $error("p_hold_flags_r8");
    end
    if (opcode == 4'd13) begin
      p_pass_b_r5: assert (result == op_b)
        else $error("p_pass_b_r5");
    end
    if (opcode == 4'd15) begin
      p_passn_b_r5: assert (result == ~op_b)
        else $error("p_passn_b_r5");
    end
    if (set_flags && (opcode == 4'd0 || opcode == 4'd1 || opcode >= 4'd12)) begin
      p_logic_cv_r10: assert (flags_out[1] == shift_carry && flags_out[0] == flags_in[0])
        else $error("p_logic_cv_r10");
    end
    if (opcode == 4'd10) begin
      p_cmp_carry_r9: assert (flags_out[1] == (op_a >= op_b))
        else $error("p_cmp_carry_r9");
      p_cmp_zero_r7: assert (flags_out[2] == (op_a == op_b))
        else $error("p_cmp_zero_r7");
    end
    if (opcode == 4'd14 && set_flags) begin
      p_clear_neg_r7: assert (flags_out[3] == (op_a[W-1] & ~op_b[W-1]))
        else $error("p_clear_neg_r7");
    end
  end

endmodule

// File: tb/tb_flag_alu.sv
module tb_flag_alu;

  logic        clk = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [3:0]  opcode = '0;
  logic        set_flags = 1'b0;
  logic [3:0]  flags_in = '0;
  logic        shift_carry = 1'b0;
  logic [31:0] result;
  logic        result_valid;
  logic [3:0]  flags_out;

  always #10 clk = ~clk;  // 50 MHz

  flag_alu dut (
    .op_a         (op_a),
    .op_b         (op_b),
    .opcode       (opcode),
    .set_flags    (set_flags),
    .flags_in     (flags_in),
    .shift_carry  (shift_carry),
    .result       (result),
    .result_valid (result_valid),
    .flags_out    (flags_out)
  );

  typedef struct {
    logic [31:0] r;
    logic        v;
    logic [3:0]  f;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   drv_done = 1'b0;

  function automatic exp_t model(logic [31:0] a, logic [31:0] b, logic [3:0] op,
                                 logic sf, logic [3:0] fl, logic sc, string tag);
    exp_t   e;
    logic [31:0] r;
    bit     arith = 1'b1;
    bit     co = 1'b0;
    bit     ci = fl[1];
    bit     bor = ~fl[1];
    longint ua = longint'({32'd0, a});
    longint ub = longint'({32'd0, b});
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint sr = 0;
    bit     probe = (op >= 4'd8 && op <= 4'd11);
    case (op)
      4'd4, 4'd11: begin r = a + b; co = (ua + ub) > 64'hFFFF_FFFF; sr = sa + sb; end
      4'd5: begin r = a + b + {31'd0, ci}; co = (ua + ub + ci) > 64'hFFFF_FFFF; sr = sa + sb + ci; end
      4'd2, 4'd10: begin r = a - b; co = ua >= ub; sr = sa - sb; end
      4'd6: begin r = a - b - {31'd0, bor}; co = ua >= ub + bor; sr = sa - sb - bor; end
      4'd3: begin r = b - a; co = ub >= ua; sr = sb - sa; end
      4'd7: begin r = b - a - {31'd0, bor}; co = ub >= ua + bor; sr = sb - sa - bor; end
      4'd0, 4'd8: begin r = a & b; arith = 1'b0; end
      4'd1, 4'd9: begin r = a ^ b; arith = 1'b0; end
      4'd12: begin r = a | b; arith = 1'b0; end
      4'd13: begin r = b; arith = 1'b0; end
      4'd14: begin r = a & ~b; arith = 1'b0; end
      default: begin r = ~b; arith = 1'b0; end
    endcase
    e.r = probe ? 32'd0 : r;
    e.v = ~probe;
    e.f = fl;
    if (probe || sf) begin
      e.f[3] = r[31];
      e.f[2] = (r == 32'd0);
      e.f[1] = arith ? co : sc;
      e.f[0] = arith ? ((sr > 64'sd2147483647) || (sr < -64'sd2147483648)) : fl[0];
    end
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic sf,
                       logic [3:0] fl, logic sc, string tag);
    @(posedge clk);
    op_a = a; op_b = b; opcode = op; set_flags = sf; flags_in = fl; shift_carry = sc;
    q.push_back(model(a, b, op, sf, fl, sc, tag));
  endtask

  // Monitor: compare at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if (result !== e.r || result_valid !== e.v || flags_out !== e.f) begin
          n_bad++;
          $display("FAIL %s: got r=%h v=%b f=%b expected r=%h v=%b f=%b",
                   e.tag, result, result_valid, flags_out, e.r, e.v, e.f);
        end
      end
    end
  end

  // Driver
  initial begin
    logic [31:0] seed;
    seed = 32'h1234_5678;
    // R11 idle state: AND of zeros
    drive(4'd0, 32'd0, 32'd0, 1'b0, 4'b0000, 1'b0, "R11 idle");
    // R1 add boundaries
    drive(4'd4, 32'hFFFF_FFFF, 32'd1, 1'b1, 4'b0000, 1'b0, "R1 add wrap, R7 Z, R9 C");
    drive(4'd4, 32'h7FFF_FFFF, 32'd1, 1'b1, 4'b0000, 1'b0, "R9 add overflow, R7 N");
    drive(4'd5, 32'd10, 32'd20, 1'b1, 4'b0010, 1'b0, "R1 addc with C");
    drive(4'd2, 32'd5, 32'd5, 1'b1, 4'b0000, 1'b0, "R1 sub equal, R9 no borrow");
    drive(4'd2, 32'd3, 32'd5, 1'b1, 4'b0010, 1'b0, "R9 sub borrow");
    drive(4'd2, 32'h8000_0000, 32'd1, 1'b1, 4'b0000, 1'b0, "R9 sub overflow");
    drive(4'd3, 32'd7, 32'd100, 1'b1, 4'b0000, 1'b0, "R2 rsub");
    drive(4'd7, 32'd7, 32'd100, 1'b1, 4'b0000, 1'b0, "R2 rsubc borrow");
    drive(4'd7, 32'd7, 32'd100, 1'b1, 4'b0010, 1'b0, "R2 rsubc no borrow");
    drive(4'd6, 32'd50, 32'd8, 1'b1, 4'b0000, 1'b0, "R3 subc borrow");
    drive(4'd6, 32'd50, 32'd8, 1'b1, 4'b0010, 1'b0, "R3 subc no borrow");
    drive(4'd0, 32'hF0F0_1234, 32'h0FF0_FFFF, 1'b1, 4'b0001, 1'b1, "R4 and, R10 C from shifter V kept");
    drive(4'd1, 32'hAAAA_5555, 32'hFFFF_0000, 1'b1, 4'b0000, 1'b0, "R4 xor");
    drive(4'd12, 32'h0000_00F0, 32'h0F00_0000, 1'b1, 4'b1111, 1'b0, "R4 or, R10");
    drive(4'd14, 32'hFFFF_FFFF, 32'h0000_FF00, 1'b1, 4'b0000, 1'b1, "R4 clear");
    drive(4'd13, 32'hDEAD_BEEF, 32'h1234_5678, 1'b0, 4'b0101, 1'b0, "R5 pass");
    drive(4'd13, 32'h0000_0000, 32'h1234_5678, 1'b0, 4'b0101, 1'b0, "R5 pass other a");
    drive(4'd15, 32'hDEAD_BEEF, 32'h0000_0000, 1'b1, 4'b0000, 1'b0, "R5 passn");
    drive(4'd10, 32'd9, 32'd9, 1'b0, 4'b0000, 1'b0, "R6 cmp no sf");
    drive(4'd11, 32'hFFFF_FFFF, 32'd1, 1'b0, 4'b1001, 1'b0, "R6 cmpadd");
    drive(4'd8, 32'hF000_0000, 32'h8000_0000, 1'b0, 4'b0001, 1'b1, "R6 tstand");
    drive(4'd9, 32'h1234, 32'h1234, 1'b0, 4'b1010, 1'b0, "R6 tstxor zero");
    drive(4'd4, 32'hFFFF_FFFF, 32'd1, 1'b0, 4'b1010, 1'b0, "R8 add no sf");
    drive(4'd0, 32'd0, 32'd0, 1'b0, 4'b0101, 1'b1, "R8 and no sf");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb, rc;
      seed = seed * 32'd1664525 + 32'd1013904223; ra = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; rb = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; rc = seed;
      if (rc[20]) rb = ra;
      drive(rc[3:0], ra, rb, rc[8], rc[15:12], rc[16], "R1 R7 R9 R10 sweep");
    end
    @(posedge clk);
    while (q.size() > 0) @(posedge clk);
    drv_done = 1'b1;
  end

  // Watchdog and summary
  initial begin
    int cyc;
    cyc = 0;
    while (!drv_done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!drv_done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule